// File: doc/BRIEF.md
# Bidirectional Dual FIFO Controller

This block holds two independent first-in first-out queues side by side. One carries words from port A to port B. The other carries words from port B back to port A. Port A is the control side. Besides moving data, it reaches a small register file: a command register, a status register and eight configuration registers. A register-select input chooses between a register access and a data access. Port B only writes and reads data.

A short 9-bit message can be sent from port A straight to port B through a command code. The message does not pass through either queue. The command register also resets either queue's pointers on its own, or both together, and clears the sticky error flags.

A build parameter selects the data width. In narrow mode each data port is 18 bits wide. In wide mode two 18-bit storage lanes are cascaded, so each port carries one 36-bit word. The queue depth is a parameter and defaults to 512 words per direction.

Top module: `duplex_queue_ctrl`

## Requirements
- R1: Words written at port A with `a_wr` high and `a_reg` low leave port B in the same order. Each `b_rd` to a non-empty queue raises `b_rvalid` with the word on `b_rdata` in the cycle after the read.
- R2: Words written at port B with `b_wr` come back at port A in the same order. Each `a_rd` with `a_reg` low to a non-empty queue raises `a_rvalid` with the word on `a_rdata` in the cycle after the read.
- R3: Each queue holds exactly DEPTH words. A write to a full queue is dropped and leaves the queue contents unchanged. Such a write sets the sticky error flag of that queue: status bit 4 for the A-to-B queue, status bit 5 for the B-to-A queue.
- R4: A read from an empty queue returns no valid strobe and leaves the queue unchanged. It sets the same sticky error flag of that queue.
- R5: The command register sits at address 0, with an operation code in bits 11:9:
   - code 1 empties the A-to-B queue;
   - code 2 empties the B-to-A queue;
   - code 3 empties both queues;
   - code 5 clears both error flags.
  Emptying one queue leaves the other queue's contents intact.
- R6: Command code 4 places bits 8:0 of the written word on `byp_msg` and raises `byp_valid` for exactly the cycle after the write. Neither queue changes. `byp_valid` stays low in every other cycle.
- R7: The register map is as follows:
   - address 0 reads back the last written command word;
   - address 1 is the status register, and writes to it are ignored;
   - addresses 2 to 9 are eight 18-bit read/write configuration registers;
   - addresses 10 to 15 read as zero.
  Register read data appears on `a_rdata` with `a_rvalid` in the cycle after `a_rd` with `a_reg` high.
- R8: Status bits are: 0 A-to-B empty, 1 A-to-B full, 2 B-to-A empty, 3 B-to-A full, 4 A-to-B error, 5 B-to-A error; the rest read zero. Reading the status register changes nothing.
- R9: After reset both queues are empty, the error flags, command and configuration registers are zero, and `a_rvalid`, `b_rvalid` and `byp_valid` are low.
- R10: With WIDE set to 1, both data ports are 36 bits wide. Each queue entry carries all 36 bits in order, at the same depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Port A write strobe |
| a_rd | input | 1 | Port A read strobe |
| a_reg | input | 1 | 1: register access, 0: queue access |
| a_addr | input | 4 | Register address |
| a_wdata | input | 18·(WIDE+1) | Port A write data |
| a_rdata | output | 18·(WIDE+1) | Port A read data (queue word or zero-extended register) |
| a_rvalid | output | 1 | Port A read data valid |
| b_wr | input | 1 | Port B write strobe |
| b_wdata | input | 18·(WIDE+1) | Port B write data |
| b_rd | input | 1 | Port B read strobe |
| b_rdata | output | 18·(WIDE+1) | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| byp_valid | output | 1 | Bypass message strobe |
| byp_msg | output | 9 | Bypass message |

## Verification
Each queue is tried with several input patterns, and each pattern separates a different kind of fault:
- Short bursts followed by drains show ordering and one-cycle read latency.
- A full fill followed by one extra write shows whether the depth limit is off by one and whether the overflow word leaks in.
- A read from an empty queue shows whether an underflow strobe is raised.
- Concurrent writes and reads on one queue show whether the occupancy count is updated correctly when both happen in the same cycle.

Resetting one queue while the other holds data shows that the two clears are independent. Bypass commands between queue traffic show that the message path does not touch either queue. A second instance in wide mode shows that both 18-bit lanes stay aligned.

// File: rtl/dq_pkg.sv
package dq_pkg;
   localparam int ADDR_W   = 4;
   localparam int REG_CMD  = 0;
   localparam int REG_STAT = 1;
   localparam int REG_CFG0 = 2;
   localparam int N_CFG    = 8;
   localparam int OP_LSB   = 9;
   localparam int OP_W     = 3;
   localparam int BYP_W    = 9;

   typedef enum logic [OP_W-1:0] {
      OP_NOP      = 3'd0,
      OP_CLR_AB   = 3'd1,
      OP_CLR_BA   = 3'd2,
      OP_CLR_BOTH = 3'd3,
      OP_BYPASS   = 3'd4,
      OP_CLR_ERR  = 3'd5
   } dq_op_e;

   // first field is the most significant bit
   typedef struct packed {
      logic ba_err;
      logic ab_err;
      logic ba_full;
      logic ba_empty;
      logic ab_full;
      logic ab_empty;
   } dq_stat_t;
endpackage

// File: rtl/dq_ptr.sv
module dq_ptr #(
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          empty,
   output logic          full
);
   logic [CW-1:0] count;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign push_ok = push & ~full & ~clr;
   assign pop_ok  = pop & ~empty & ~clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/dq_ram.sv
module dq_ram #(
   parameter int W     = 18,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/dq_regfile.sv
module dq_regfile
   import dq_pkg::*;
#(
   parameter int REG_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              ab_empty,
   input  logic              ab_full,
   input  logic              ba_empty,
   input  logic              ba_full,
   input  logic              ab_err_set,
   input  logic              ba_err_set,
   output logic [REG_W-1:0]  rdata,
   output logic              rvalid,
   output logic              clr_ab,
   output logic              clr_ba,
   output logic              byp_valid,
   output logic [BYP_W-1:0]  byp_msg
);
   logic             reg_wr, reg_rd, cmd_wr, err_clr, byp_go;
   dq_op_e           op;
   logic [REG_W-1:0] cmd_q;
   logic [REG_W-1:0] cfg_q [N_CFG];
   logic             ab_err_q, ba_err_q;
   dq_stat_t         stat;
   logic [REG_W-1:0] rmux;

   assign reg_wr  = wr & sel;
   assign reg_rd  = rd & sel;
   assign cmd_wr  = reg_wr & (addr == ADDR_W'(REG_CMD));
   assign op      = dq_op_e'(wdata[OP_LSB +: OP_W]);
   assign clr_ab  = cmd_wr & ((op == OP_CLR_AB) | (op == OP_CLR_BOTH));
   assign clr_ba  = cmd_wr & ((op == OP_CLR_BA) | (op == OP_CLR_BOTH));
   assign err_clr = cmd_wr & (op == OP_CLR_ERR);
   assign byp_go  = cmd_wr & (op == OP_BYPASS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         ab_err_q  <= 1'b0;
         ba_err_q  <= 1'b0;
         byp_valid <= 1'b0;
         byp_msg   <= '0;
      end else begin
         if (cmd_wr) cmd_q <= wdata;
         // a new error in the same cycle wins over a clear
         ab_err_q  <= ab_err_set | (ab_err_q & ~err_clr);
         ba_err_q  <= ba_err_set | (ba_err_q & ~err_clr);
         byp_valid <= byp_go;
         if (byp_go) byp_msg <= wdata[BYP_W-1:0];
      end
   end

   for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n)
            cfg_q[i] <= '0;
         else if (reg_wr && addr == ADDR_W'(REG_CFG0 + i))
            cfg_q[i] <= wdata;
      end
   end

   always_comb begin
      stat.ab_empty = ab_empty;
      stat.ab_full  = ab_full;
      stat.ba_empty = ba_empty;
      stat.ba_full  = ba_full;
      stat.ab_err   = ab_err_q;
      stat.ba_err   = ba_err_q;
   end

   always_comb begin
      rmux = '0;
      if (addr == ADDR_W'(REG_CMD))
         rmux = cmd_q;
      else if (addr == ADDR_W'(REG_STAT))
         rmux = REG_W'(stat);
      else
         for (int i = 0; i < N_CFG; i++)
            if (addr == ADDR_W'(REG_CFG0 + i)) rmux = cfg_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= reg_rd;
         if (reg_rd) rdata <= rmux;
      end
   end
endmodule

// File: rtl/duplex_queue_ctrl.sv
module duplex_queue_ctrl
   import dq_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int DEPTH  = 512,
   parameter int WIDE   = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         a_wr,
   input  logic                         a_rd,
   input  logic                         a_reg,
   input  logic [3:0]                   a_addr,
   input  logic [DATA_W*(WIDE+1)-1:0]   a_wdata,
   output logic [DATA_W*(WIDE+1)-1:0]   a_rdata,
   output logic                         a_rvalid,
   input  logic                         b_wr,
   input  logic [DATA_W*(WIDE+1)-1:0]   b_wdata,
   input  logic                         b_rd,
   output logic [DATA_W*(WIDE+1)-1:0]   b_rdata,
   output logic                         b_rvalid,
   output logic                         byp_valid,
   output logic [8:0]                   byp_msg
);
   localparam int LANES = WIDE + 1;
   localparam int PW    = DATA_W * LANES;
   localparam int AW    = $clog2(DEPTH);

   initial begin
      assert (DATA_W >= OP_LSB + OP_W)
         else $error("DATA_W too narrow for the command word");
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 4");
      assert (WIDE == 0 || WIDE == 1)
         else $error("WIDE must be 0 or 1");
   end

   logic          a_dwr, a_drd;
   logic          clr_ab, clr_ba;
   logic [AW-1:0] ab_wptr, ab_rptr, ba_wptr, ba_rptr;
   logic          ab_push_ok, ab_pop_ok, ab_empty, ab_full;
   logic          ba_push_ok, ba_pop_ok, ba_empty, ba_full;
   logic          ab_err_set, ba_err_set;
   logic [PW-1:0] ab_q, ba_q;
   logic          b_rv_q, a_qrv_q;
   logic [DATA_W-1:0] reg_rdata;
   logic          reg_rvalid;

   assign a_dwr = a_wr & ~a_reg;
   assign a_drd = a_rd & ~a_reg;

   dq_ptr #(.DEPTH(DEPTH)) u_ab_ptr (
      .clk(clk), .rst_n(rst_n), .clr(clr_ab), .push(a_dwr), .pop(b_rd),
      .wptr(ab_wptr), .rptr(ab_rptr), .push_ok(ab_push_ok),
      .pop_ok(ab_pop_ok), .empty(ab_empty), .full(ab_full));

   dq_ptr #(.DEPTH(DEPTH)) u_ba_ptr (
      .clk(clk), .rst_n(rst_n), .clr(clr_ba), .push(b_wr), .pop(a_drd),
      .wptr(ba_wptr), .rptr(ba_rptr), .push_ok(ba_push_ok),
      .pop_ok(ba_pop_ok), .empty(ba_empty), .full(ba_full));

   // one storage slice per lane and direction; lanes share pointers
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dq_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ab_ram (
         .clk(clk), .we(ab_push_ok), .waddr(ab_wptr),
         .wdata(a_wdata[g*DATA_W +: DATA_W]),
         .re(ab_pop_ok), .raddr(ab_rptr),
         .rdata(ab_q[g*DATA_W +: DATA_W]));
      dq_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ba_ram (
         .clk(clk), .we(ba_push_ok), .waddr(ba_wptr),
         .wdata(b_wdata[g*DATA_W +: DATA_W]),
         .re(ba_pop_ok), .raddr(ba_rptr),
         .rdata(ba_q[g*DATA_W +: DATA_W]));
   end

   assign ab_err_set = (a_dwr & ab_full) | (b_rd & ab_empty);
   assign ba_err_set = (b_wr & ba_full) | (a_drd & ba_empty);

   dq_regfile #(.REG_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(a_wr), .rd(a_rd), .sel(a_reg),
      .addr(a_addr), .wdata(a_wdata[DATA_W-1:0]),
      .ab_empty(ab_empty), .ab_full(ab_full),
      .ba_empty(ba_empty), .ba_full(ba_full),
      .ab_err_set(ab_err_set), .ba_err_set(ba_err_set),
      .rdata(reg_rdata), .rvalid(reg_rvalid),
      .clr_ab(clr_ab), .clr_ba(clr_ba),
      .byp_valid(byp_valid), .byp_msg(byp_msg));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_rv_q  <= 1'b0;
         a_qrv_q <= 1'b0;
      end else begin
         b_rv_q  <= ab_pop_ok;
         a_qrv_q <= ba_pop_ok;
      end
   end

   generate
      if (WIDE != 0) begin : g_wide_out
         assign a_rdata = a_qrv_q ? ba_q : {{(PW-DATA_W){1'b0}}, reg_rdata};
      end else begin : g_narrow_out
         assign a_rdata = a_qrv_q ? ba_q : reg_rdata;
      end
   endgenerate

   assign a_rvalid = a_qrv_q | reg_rvalid;
   assign b_rdata  = ab_q;
   assign b_rvalid = b_rv_q;
endmodule

// File: rtl/dq_chk.sv
module dq_chk #(
   parameter int PW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          a_wr,
   input logic          a_rd,
   input logic          a_reg,
   input logic [3:0]    a_addr,
   input logic [PW-1:0] a_wdata,
   input logic          b_wr,
   input logic          b_rd,
   input logic          b_rvalid,
   input logic          byp_valid,
   input logic [8:0]    byp_msg,
   input logic          ab_full,
   input logic          ab_empty,
   input logic          ba_empty,
   input logic          clr_ab
);
   logic byp_cmd;
   assign byp_cmd = a_wr && a_reg && a_addr == 4'd0 && a_wdata[11:9] == 3'd4;

   // R3
   ab_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_full && a_wr && !a_reg && !b_rd && !clr_ab) |=> ab_full);

   // R4
   ab_empty_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_empty && b_rd) |=> !b_rvalid);

   // R5
   ab_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ab |=> (ab_empty && !ab_full));

   // R6
   byp_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byp_cmd |=> (byp_valid && byp_msg == $past(a_wdata[8:0])));

   // R6
   byp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byp_cmd |=> !byp_valid);

   // R8
   stat_read_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && a_reg && a_addr == 4'd1 && !a_wr && !b_wr && !b_rd)
      |=> ($stable(ab_empty) && $stable(ba_empty)));
endmodule

bind duplex_queue_ctrl dq_chk #(.PW(DATA_W*(WIDE+1))) u_chk (
   .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .a_rd(a_rd), .a_reg(a_reg),
   .a_addr(a_addr), .a_wdata(a_wdata), .b_wr(b_wr), .b_rd(b_rd),
   .b_rvalid(b_rvalid), .byp_valid(byp_valid), .byp_msg(byp_msg),
   .ab_full(ab_full), .ab_empty(ab_empty), .ba_empty(ba_empty),
   .clr_ab(clr_ab));

// File: tb/sim_duplex_queue_ctrl.sv
module sim_duplex_queue_ctrl;
   localparam int DW    = 18;
   localparam int DEPTH = 512;
   localparam int WD    = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          a_wr, a_rd, a_reg, b_wr, b_rd;
   logic [3:0]    a_addr;
   logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
   logic          a_rvalid, b_rvalid, byp_valid;
   logic [8:0]    byp_msg;

   logic          w_a_wr, w_a_rd, w_b_wr, w_b_rd;
   logic [35:0]   w_a_wdata, w_b_wdata, w_a_rdata, w_b_rdata;
   logic          w_a_rvalid, w_b_rvalid, w_byp_valid;
   logic [8:0]    w_byp_msg;

   duplex_queue_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .WIDE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .a_rd(a_rd), .a_reg(a_reg),
      .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .a_rvalid(a_rvalid), .b_wr(b_wr), .b_wdata(b_wdata), .b_rd(b_rd),
      .b_rdata(b_rdata), .b_rvalid(b_rvalid), .byp_valid(byp_valid),
      .byp_msg(byp_msg));

   duplex_queue_ctrl #(.DATA_W(DW), .DEPTH(WD), .WIDE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .a_wr(w_a_wr), .a_rd(w_a_rd), .a_reg(1'b0),
      .a_addr(4'd0), .a_wdata(w_a_wdata), .a_rdata(w_a_rdata),
      .a_rvalid(w_a_rvalid), .b_wr(w_b_wr), .b_wdata(w_b_wdata),
      .b_rd(w_b_rd), .b_rdata(w_b_rdata), .b_rvalid(w_b_rvalid),
      .byp_valid(w_byp_valid), .byp_msg(w_byp_msg));

   int n_chk  = 0;
   int n_fail = 0;
   string cur_req = "R9";

   logic [DW-1:0] ab_model[$];
   logic [DW-1:0] ba_model[$];
   logic [DW-1:0] qa_exp[$];
   logic [DW-1:0] qb_exp[$];
   logic ab_err = 1'b0;
   logic ba_err = 1'b0;
   logic [35:0] wexp[$];

   task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] stat_exp();
      return DW'({ba_err, ab_err, ba_model.size() == DEPTH, ba_model.size() == 0,
                  ab_model.size() == DEPTH, ab_model.size() == 0});
   endfunction

   // scoreboard monitors, sampled away from the rising edge
   always @(negedge clk) begin
      if (rst_n && b_rvalid) begin
         if (qb_exp.size() == 0) chk({cur_req, " unexpected b_rvalid"}, 36'd1, 36'd0);
         else chk(cur_req, 36'(b_rdata), 36'(qb_exp.pop_front()));
      end
      if (rst_n && a_rvalid) begin
         if (qa_exp.size() == 0) chk({cur_req, " unexpected a_rvalid"}, 36'd1, 36'd0);
         else chk(cur_req, 36'(a_rdata), 36'(qa_exp.pop_front()));
      end
      if (rst_n && w_b_rvalid) begin
         if (wexp.size() == 0) chk("R10 unexpected wide rvalid", 36'd1, 36'd0);
         else chk("R10", w_b_rdata, wexp.pop_front());
      end
      if (rst_n && w_a_rvalid) begin
         if (wexp.size() == 0) chk("R10 unexpected wide rvalid", 36'd1, 36'd0);
         else chk("R10", w_a_rdata, wexp.pop_front());
      end
   end

   task automatic release_inputs();
      @(posedge clk);
      #1;
      a_wr = 0; a_rd = 0; a_reg = 0; b_wr = 0; b_rd = 0;
      w_a_wr = 0; w_a_rd = 0; w_b_wr = 0; w_b_rd = 0;
   endtask

   task automatic a_push(logic [DW-1:0] d);
      @(negedge clk);
      a_wr = 1; a_reg = 0; a_wdata = d;
      if (ab_model.size() < DEPTH) ab_model.push_back(d); else ab_err = 1;
      release_inputs();
   endtask

   task automatic b_push(logic [DW-1:0] d);
      @(negedge clk);
      b_wr = 1; b_wdata = d;
      if (ba_model.size() < DEPTH) ba_model.push_back(d); else ba_err = 1;
      release_inputs();
   endtask

   task automatic b_pop();
      @(negedge clk);
      b_rd = 1;
      if (ab_model.size() > 0) qb_exp.push_back(ab_model.pop_front()); else ab_err = 1;
      release_inputs();
   endtask

   task automatic a_pop();
      @(negedge clk);
      a_rd = 1; a_reg = 0;
      if (ba_model.size() > 0) qa_exp.push_back(ba_model.pop_front()); else ba_err = 1;
      release_inputs();
   endtask

   // concurrent write at A and read at B on the same queue
   task automatic ab_both(logic [DW-1:0] d);
      int s;
      @(negedge clk);
      s = ab_model.size();
      a_wr = 1; a_reg = 0; a_wdata = d; b_rd = 1;
      if (s > 0) qb_exp.push_back(ab_model.pop_front()); else ab_err = 1;
      if (s < DEPTH) ab_model.push_back(d); else ab_err = 1;
      release_inputs();
   endtask

   task automatic reg_wr(logic [3:0] adr, logic [DW-1:0] d);
      @(negedge clk);
      a_wr = 1; a_reg = 1; a_addr = adr; a_wdata = d;
      release_inputs();
   endtask

   task automatic reg_rd(logic [3:0] adr, logic [DW-1:0] exp);
      @(negedge clk);
      a_rd = 1; a_reg = 1; a_addr = adr;
      qa_exp.push_back(exp);
      release_inputs();
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (qa_exp.size() != 0 || qb_exp.size() != 0 || wexp.size() != 0)
         chk("missing results", 36'(qa_exp.size() + qb_exp.size() + wexp.size()), 36'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0;
      a_wr = 0; a_rd = 0; a_reg = 0; b_wr = 0; b_rd = 0;
      a_addr = 0; a_wdata = 0; b_wdata = 0;
      w_a_wr = 0; w_a_rd = 0; w_b_wr = 0; w_b_rd = 0;
      w_a_wdata = 0; w_b_wdata = 0;
      idle(4);
      @(negedge clk);
      rst_n = 1;
      idle(1);

      // R9 reset state
      cur_req = "R9";
      chk("R9 a_rvalid", 36'(a_rvalid), 36'd0);
      chk("R9 b_rvalid", 36'(b_rvalid), 36'd0);
      chk("R9 byp_valid", 36'(byp_valid), 36'd0);
      reg_rd(4'd1, stat_exp());
      reg_rd(4'd0, '0);
      reg_rd(4'd5, '0);
      idle(2);

      // R1 A to B ordering with gaps
      cur_req = "R1";
      for (int i = 0; i < 5; i++) a_push(DW'(18'h10 + i * 7));
      for (int i = 0; i < 5; i++) b_pop();
      idle(2);

      // R2 B to A ordering
      cur_req = "R2";
      for (int i = 0; i < 6; i++) b_push(DW'(18'h3F000 ^ (i * 18'h111)));
      for (int i = 0; i < 6; i++) a_pop();
      idle(2);

      // R1 concurrent push and pop
      cur_req = "R1";
      a_push(18'h2AAAA);
      for (int i = 0; i < 4; i++) ab_both(DW'(18'h1000 + i));
      b_pop();
      idle(2);

      // R3 fill to depth, one extra write is dropped
      cur_req = "R3";
      for (int i = 0; i < DEPTH; i++) a_push(DW'(i * 3 + 1));
      reg_rd(4'd1, stat_exp());
      a_push(18'h3FFFF);
      reg_rd(4'd1, stat_exp());
      idle(2);
      chk("R3 model error flag", 36'(ab_err), 36'd1);
      for (int i = 0; i < DEPTH; i++) b_pop();
      idle(2);
      reg_rd(4'd1, stat_exp());
      idle(2);

      // R5 clear errors
      cur_req = "R5";
      reg_wr(4'd0, {6'd0, 3'd5, 9'd0});
      ab_err = 0; ba_err = 0;
      reg_rd(4'd1, stat_exp());
      idle(2);

      // R4 read from empty B to A queue
      cur_req = "R4";
      a_pop();
      idle(2);
      reg_rd(4'd1, stat_exp());
      idle(2);
      chk("R4 err expected", 36'(ba_err), 36'd1);
      b_push(18'h0ABCD);
      a_pop();
      idle(2);

      // R5 independent queue reset
      cur_req = "R5";
      for (int i = 0; i < 3; i++) a_push(DW'(18'h500 + i));
      for (int i = 0; i < 3; i++) b_push(DW'(18'h600 + i));
      reg_wr(4'd0, {6'd0, 3'd1, 9'd0});
      ab_model.delete();
      reg_rd(4'd1, stat_exp());
      reg_rd(4'd0, {6'd0, 3'd1, 9'd0});
      for (int i = 0; i < 3; i++) a_pop();
      idle(2);
      b_push(18'h777);
      a_push(18'h888);
      reg_wr(4'd0, {6'd0, 3'd3, 9'd0});
      ab_model.delete();
      ba_model.delete();
      reg_rd(4'd1, stat_exp());
      idle(2);

      // R6 bypass message
      cur_req = "R6";
      a_push(18'h0C0DE);
      reg_wr(4'd0, {6'd0, 3'd4, 9'h1A5});
      chk("R6 byp_valid", 36'(byp_valid), 36'd1);
      chk("R6 byp_msg", 36'(byp_msg), 36'h1A5);
      idle(1);
      chk("R6 byp_valid pulse", 36'(byp_valid), 36'd0);
      reg_rd(4'd1, stat_exp());
      b_pop();
      idle(2);
      chk("R6 no bypass on data write", 36'(byp_valid), 36'd0);

      // R7 register map
      cur_req = "R7";
      reg_rd(4'd4, '0);
      for (int i = 0; i < 8; i++) reg_wr(4'(2 + i), DW'(18'h2B000 + i * 18'h123));
      for (int i = 0; i < 8; i++) reg_rd(4'(2 + i), DW'(18'h2B000 + i * 18'h123));
      reg_wr(4'd1, 18'h3FFFF);
      reg_rd(4'd1, stat_exp());
      reg_wr(4'd12, 18'h15555);
      reg_rd(4'd12, '0);
      reg_rd(4'd0, {6'd0, 3'd4, 9'h1A5});
      idle(2);

      // R8 status reads do not disturb data
      cur_req = "R8";
      b_push(18'h12345);
      reg_rd(4'd1, stat_exp());
      reg_rd(4'd1, stat_exp());
      a_pop();
      idle(2);
      reg_rd(4'd1, stat_exp());
      idle(2);

      // R10 wide instance
      cur_req = "R10";
      @(negedge clk);
      w_a_wr = 1; w_a_wdata = 36'h9ABCD1234;
      release_inputs();
      @(negedge clk);
      w_a_wr = 1; w_a_wdata = 36'h3C0FF0E1D;
      release_inputs();
      @(negedge clk);
      w_b_rd = 1; wexp.push_back(36'h9ABCD1234);
      release_inputs();
      @(negedge clk);
      w_b_rd = 1; wexp.push_back(36'h3C0FF0E1D);
      release_inputs();
      idle(2);
      @(negedge clk);
      w_b_wr = 1; w_b_wdata = 36'hF0000FFFF;
      release_inputs();
      @(negedge clk);
      w_a_rd = 1; wexp.push_back(36'hF0000FFFF);
      release_inputs();
      idle(3);

      finish_run();
   end
endmodule